// File: doc/BRIEF.md
# Prescaled Pin Deglitch Filter

This block sits between the synchronized pin inputs of a general-purpose I/O controller and its input and interrupt logic. It removes short glitches. Each pin has its own lane. A lane passes a new input level to its output only after the level has held steady for a programmed time.

The time base is a shared tick that fires once every four enabled clock cycles. Within each lane, a prescaler counts `clk_cnt + 1` ticks to make one filter step. The new level is accepted after `flt_cnt` consecutive steps. The filter time is therefore `(clk_cnt + 1) * flt_cnt * 4` clock cycles. Software picks the two fields so that this product matches the wanted duration at the clock frequency it runs on.

A lane whose filter count is zero is bypassed. If the input returns to the filtered level, the lane's prescaler and step counter restart from zero.

Top module: `pin_deglitch`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every lane's filtered level is 0, whatever `raw_in` is (when that lane's filter count is non-zero).
- R2: A lane whose filter count is 0 is bypassed. Its `filt_out` bit equals its `raw_in` bit combinationally, in the same cycle.
- R3: The tick fires on every fourth clock cycle with `clk_en` high. A lane whose input differs from its filtered level changes its output after exactly `(clk_cnt+1)*flt_cnt` ticks. Measured from the first clock edge after the input changes, the change appears after between `4N-3` and `4N` edges, where `N = (clk_cnt+1)*flt_cnt`.
- R4: Rising and falling input changes are filtered with the same delay.
- R5: An input pulse shorter than the filter time leaves the output unchanged.
- R6: An input that returns to the filtered level, even for one cycle, restarts the lane's timing. The next change again needs the full filter time.
- R7: While `clk_en` is low, no tick occurs and no lane makes progress. After `clk_en` rises, the full delay of R3 still applies.
- R8: Each lane uses only its own two fields (`flt_cnt_in` bits `[p*FLT_W +: FLT_W]`, `clk_cnt_in` bits `[p*PRE_W +: PRE_W]`), so lanes with different settings have independent delays.
- R9: The largest field values (all ones in both fields) give the full `2^PRE_W * (2^FLT_W-1)` ticks, with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Enables the quarter-rate tick |
| raw_in | input | NUM_PINS | Synchronized raw pin levels |
| flt_cnt_in | input | NUM_PINS*FLT_W | Per-lane filter step count; 0 bypasses the lane |
| clk_cnt_in | input | NUM_PINS*PRE_W | Per-lane prescaler reload; a step lasts this value plus one ticks |
| filt_out | output | NUM_PINS | Filtered pin levels |

## Verification
The bench builds the block with two lanes and 4-bit fields, in place of the 8-bit defaults. With 4-bit fields the all-ones setting takes 960 cycles rather than about a quarter of a million. This brings the maximum-value corner of R9 within reach of a short run. It also leaves enough range to show two lanes settling at different times. Delays are checked against the four-cycle window set by the phase of the shared tick. The `clk_en` case is exact, because the tick phase is frozen while `clk_en` is low.

// File: rtl/pin_deglitch_pkg.sv
package pin_deglitch_pkg;

    // Division between the module clock and the filter time base.
    localparam int unsigned DG_TICK_DIV = 4;

    // Activity of a single lane in the current cycle.
    typedef enum logic [1:0] {
        LANE_BYPASS  = 2'd0,
        LANE_SETTLED = 2'd1,
        LANE_PENDING = 2'd2
    } lane_mode_e;

    // A zero filter count takes priority over everything else.
    function automatic lane_mode_e classify_lane(input logic cnt_zero,
                                                 input logic differs);
        if (cnt_zero)
            return LANE_BYPASS;
        else if (differs)
            return LANE_PENDING;
        else
            return LANE_SETTLED;
    endfunction

endpackage

// File: rtl/pdg_quarter_tick.sv
module pdg_quarter_tick #(
    parameter int unsigned TICK_DIV = pin_deglitch_pkg::DG_TICK_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    output logic tick
);
    localparam int unsigned QW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [QW-1:0] LAST = QW'(TICK_DIV - 1);

    logic [QW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (clk_en)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    assign tick = clk_en && (phase_q == LAST);

    // R7: phase frozen while the enable is low
    a_r7_phase_frozen: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(phase_q));

    // R3: ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/pdg_lane.sv
module pdg_lane
    import pin_deglitch_pkg::*;
#(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             raw,
    input  logic [FLT_W-1:0] flt_cnt,
    input  logic [PRE_W-1:0] clk_cnt,
    output logic             filt
);
    typedef struct packed {
        logic             level;
        logic [PRE_W-1:0] pre;
        logic [FLT_W-1:0] steps;
    } lane_state_t;

    lane_state_t st_q, st_d;
    lane_mode_e  mode;
    logic        step_done;
    logic        last_step;
    logic [FLT_W:0] steps_inc;

    assign mode      = classify_lane(flt_cnt == '0, raw != st_q.level);
    assign step_done = (st_q.pre >= clk_cnt);
    assign steps_inc = {1'b0, st_q.steps} + 1'b1;
    assign last_step = (steps_inc >= {1'b0, flt_cnt});

    always_comb begin
        st_d = st_q;
        unique case (mode)
            LANE_BYPASS: begin
                st_d.level = raw;
                st_d.pre   = '0;
                st_d.steps = '0;
            end
            LANE_SETTLED: begin
                st_d.pre   = '0;
                st_d.steps = '0;
            end
            LANE_PENDING: begin
                if (tick) begin
                    if (step_done) begin
                        st_d.pre = '0;
                        if (last_step) begin
                            st_d.level = raw;
                            st_d.steps = '0;
                        end else begin
                            st_d.steps = steps_inc[FLT_W-1:0];
                        end
                    end else begin
                        st_d.pre = st_q.pre + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign filt = (mode == LANE_BYPASS) ? raw : st_q.level;

    // R1: state is clear on the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (st_q.level == 1'b0 && st_q.pre == '0 && st_q.steps == '0));

    // R6: an input equal to the output keeps the level
    a_r6_hold_equal: assert property (@(posedge clk) disable iff (rst)
        (flt_cnt != '0 && raw == st_q.level) |=> $stable(st_q.level));

    // R3: a filtered level only moves on a tick
    a_r3_move_on_tick: assert property (@(posedge clk) disable iff (rst || $past(rst))
        (!$stable(st_q.level) && $past(flt_cnt) != '0) |-> $past(tick));

    // R9: step counter stays below a steady filter count
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ($stable(flt_cnt) && $past(st_q.steps) < flt_cnt) |-> st_q.steps < flt_cnt);

endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned PRE_W    = 8,
    parameter int unsigned FLT_W    = 8,
    parameter int unsigned TICK_DIV = pin_deglitch_pkg::DG_TICK_DIV
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clk_en,
    input  logic [NUM_PINS-1:0]       raw_in,
    input  logic [NUM_PINS*FLT_W-1:0] flt_cnt_in,
    input  logic [NUM_PINS*PRE_W-1:0] clk_cnt_in,
    output logic [NUM_PINS-1:0]       filt_out
);
    logic tick;

    pdg_quarter_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .tick   (tick)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
        pdg_lane #(.PRE_W(PRE_W), .FLT_W(FLT_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .raw     (raw_in[p]),
            .flt_cnt (flt_cnt_in[p*FLT_W +: FLT_W]),
            .clk_cnt (clk_cnt_in[p*PRE_W +: PRE_W]),
            .filt    (filt_out[p])
        );
    end

endmodule

// File: tb/sim_pin_deglitch.sv
module sim_pin_deglitch;
    localparam int NP = 2;
    localparam int PW = 4;
    localparam int FW = 4;

    logic clk = 0;
    logic rst = 1;
    logic clk_en = 1;
    logic [NP-1:0] raw_in = '0;
    logic [NP*FW-1:0] flt_cnt_in = '0;
    logic [NP*PW-1:0] clk_cnt_in = '0;
    logic [NP-1:0] filt_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pin_deglitch #(.NUM_PINS(NP), .PRE_W(PW), .FLT_W(FW)) u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .raw_in(raw_in),
        .flt_cnt_in(flt_cnt_in), .clk_cnt_in(clk_cnt_in), .filt_out(filt_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int p, input int fc, input int cc);
        flt_cnt_in[p*FW +: FW] = FW'(fc);
        clk_cnt_in[p*PW +: PW] = PW'(cc);
    endtask

    // Cycles until filt_out[p]==v, counted in edges after the drive.
    task automatic measure(input int p, input bit v, input int lim, output int c);
        c = 0;
        while (c < lim) begin
            @(negedge clk);
            c++;
            if (filt_out[p] == v) return;
        end
        c = -1;
    endtask

    task automatic check_window(input string req, input int c, input int n);
        check(c >= 4*n-3 && c <= 4*n, req, c, 4*n);
    endtask

    task automatic t_reset;
        cfg(0, 3, 0); cfg(1, 3, 0);
        raw_in = '1;
        rst = 1;
        repeat (3) @(negedge clk);
        check(filt_out == '0, "R1 during reset", filt_out, 0);
        rst = 0;
        @(negedge clk);
        check(filt_out == '0, "R1 after reset", filt_out, 0);
        raw_in = '0;
        repeat (30) @(negedge clk);
    endtask

    task automatic t_bypass;
        cfg(0, 0, 5);
        raw_in[0] = 1; #1;
        check(filt_out[0] == 1, "R2 bypass rise", filt_out[0], 1);
        @(negedge clk);
        raw_in[0] = 0; #1;
        check(filt_out[0] == 0, "R2 bypass fall", filt_out[0], 0);
        @(negedge clk);
    endtask

    task automatic t_delay;
        int c;
        cfg(0, 3, 1); // N = 6
        repeat (3) @(negedge clk);
        raw_in[0] = 1;
        measure(0, 1, 100, c);
        check_window("R3 rise delay N=6", c, 6);
        cfg(0, 1, 0); // N = 1
        raw_in[0] = 0;
        measure(0, 0, 100, c);
        check_window("R3 fall delay N=1", c, 1);
    endtask

    task automatic t_falling;
        int c;
        cfg(0, 2, 2); // N = 6
        raw_in[0] = 1;
        measure(0, 1, 100, c);
        check_window("R4 rise N=6", c, 6);
        repeat (5) @(negedge clk);
        raw_in[0] = 0;
        measure(0, 0, 100, c);
        check_window("R4 fall N=6", c, 6);
    endtask

    task automatic t_glitch;
        bit bad = 0;
        cfg(0, 3, 1); // 21..24 cycles needed
        raw_in[0] = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (filt_out[0] != 0) bad = 1;
        end
        raw_in[0] = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (filt_out[0] != 0) bad = 1;
        end
        check(!bad, "R5 short pulse rejected", bad, 0);
    endtask

    task automatic t_restart;
        int c;
        bit bad = 0;
        cfg(0, 3, 1);
        raw_in[0] = 1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (filt_out[0] != 0) bad = 1;
        end
        raw_in[0] = 0;
        @(negedge clk);
        raw_in[0] = 1;
        measure(0, 1, 100, c);
        check(!bad, "R6 no early change", bad, 0);
        check_window("R6 full delay after restart", c, 6);
        raw_in[0] = 0;
        measure(0, 0, 100, c);
    endtask

    task automatic t_enable;
        int c;
        bit bad = 0;
        cfg(0, 2, 1); // N = 4
        clk_en = 0;
        raw_in[0] = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (filt_out[0] != 0) bad = 1;
        end
        check(!bad, "R7 frozen while disabled", bad, 0);
        clk_en = 1;
        measure(0, 1, 100, c);
        check_window("R7 delay after enable", c, 4);
        raw_in[0] = 0;
        measure(0, 0, 100, c);
    endtask

    task automatic t_lanes;
        int c0 = -1, c1 = -1;
        cfg(0, 1, 0); // N = 1
        cfg(1, 4, 3); // N = 16
        raw_in = 2'b11;
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (c0 < 0 && filt_out[0]) c0 = i;
            if (c1 < 0 && filt_out[1]) c1 = i;
        end
        check_window("R8 lane0 own delay", c0, 1);
        check_window("R8 lane1 own delay", c1, 16);
        raw_in = 2'b00;
        repeat (80) @(negedge clk);
        check(filt_out == 2'b00, "R8 both settle low", filt_out, 0);
    endtask

    task automatic t_max;
        int c;
        cfg(0, 15, 15); // N = 240
        raw_in[0] = 1;
        measure(0, 1, 2000, c);
        check_window("R9 max fields", c, 240);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bypass();
        t_delay();
        t_falling();
        t_glitch();
        t_restart();
        t_enable();
        t_lanes();
        t_max();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule